// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic Dot Product

This block forms the inner product of K fixed coefficients with K input samples without any multiplier. A start pulse captures all K samples into per-input shift registers. The samples then leave one bit per clock, least significant bit first. On each cycle the bits of equal weight from all inputs form an address into a coefficient-sum table. A scaling accumulator adds that table word and then halves its running value.

The table uses offset coding. Each input bit counts as +1 or -1, which makes the table inversely symmetric about its midpoint, so only half of its words are kept. The bit from input 0 picks the direct half or the mirrored half. The mirrored half uses the complemented remaining address and the negated word. On the sign-bit cycle the table term is subtracted. A constant preload of minus half the coefficient sum removes the bias that offset coding introduces. One result takes N cycles and comes with a one-cycle valid flag.

Top module: `da_dot_product`

## Requirements
- R1: After reset, `valid_o` is low and `result_o` is zero.
- R2: `result_o` equals the sum over k of C[k]·x[k]. Input k sits in `x_i[k*N +: N]` as an N-bit two's complement integer. With the defaults the coefficients C are the integers 11796, -4915, 15565 and 1802, for k = 0..3, each a value scaled by 2^14. The result is signed and RES_W = COEF_W + log2(K) + N - 1 bits wide (25 with the defaults). Its LSB weight is 2^-(14+N-1) when inputs are read as fractions. The result may differ from the exact sum by at most one LSB.
- R3: `valid_o` rises exactly N clock edges after the edge that accepts a start, and it stays high for exactly one cycle.
- R4: `result_o` keeps its value until the next time `valid_o` is asserted.
- R5: A start pulse that arrives while a computation runs has no effect. The running result and its timing are unchanged, and no extra valid pulse follows.
- R6: The sign bit carries negative weight through the subtraction on the sign cycle. All inputs at -1 (all 0x80) give -128·ΣC, all zero gives 0, all at 0x7F give 127·ΣC, and mixed-sign vectors follow R2.
- R7: For the default coefficients, the accumulator never overflows its width on any step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| x_i | input | K*N | Packed input samples, input k at bits k*N +: N |
| result_o | output | RES_W | Signed dot product, held between results |
| valid_o | output | 1 | One-cycle pulse when a new result is available |

## Verification
Several properties are checked on every cycle: the valid flag lasts a single cycle and follows the sign step, the result holds between valid pulses, a start during a run does not end that run, and the guard bits of the accumulator never overflow. Only the bench scenarios can show that the arithmetic is correct. They compare results against an exact integer dot product for zero, all -1, all maximum positive, mixed-sign corners and random vectors. They also measure the latency, and they confirm that an ignored start leaves the earlier result untouched and produces no second valid pulse.

// File: rtl/da_pkg.sv
package da_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} da_state_e;

  // signed field idx of width w from a packed coefficient vector
  function automatic int coef_val(input logic [1023:0] packed_c, input int idx, input int w);
    logic [1023:0] sh;
    logic [31:0]   raw;
    int            v;
    sh  = packed_c >> (idx * w);
    raw = sh[31:0] & ((32'd1 << w) - 32'd1);
    v   = int'(raw);
    if (raw[w-1]) v = v - (1 << w);
    return v;
  endfunction
endpackage

// File: rtl/da_shift_bank.sv
module da_shift_bank #(
  parameter int K = 4,
  parameter int N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           shift_i,
  input  logic [K*N-1:0] data_i,
  output logic [K-1:0]   bits_o
);
  for (genvar k = 0; k < K; k++) begin : g_lane
    logic [N-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q <= '0;
      else if (load_i)  sr_q <= data_i[k*N +: N];
      else if (shift_i) sr_q <= sr_q >> 1;
    end
    assign bits_o[k] = sr_q[0];
  end
endmodule

// File: rtl/da_half_rom.sv
module da_half_rom
  import da_pkg::*;
#(
  parameter int               K      = 4,
  parameter int               COEF_W = 16,
  parameter logic [K*COEF_W-1:0] COEFS = '0,
  parameter int               TW     = COEF_W + $clog2(K)
) (
  input  logic [K-1:0]          bits_i,
  output logic signed [TW-1:0]  term_o
);
  localparam int HW = 1 << (K - 1);

  // half of the +/-1 weighted coefficient sum, input 0 taken as +1
  function automatic int half_word(input int a);
    int s;
    s = coef_val(1024'(COEFS), 0, COEF_W);
    for (int k = 1; k < K; k++) begin
      if (a[k-1]) s = s + coef_val(1024'(COEFS), k, COEF_W);
      else        s = s - coef_val(1024'(COEFS), k, COEF_W);
    end
    return s >>> 1;
  endfunction

  logic signed [TW-1:0] words [HW];
  for (genvar a = 0; a < HW; a++) begin : g_word
    localparam logic signed [TW-1:0] WORD = TW'(half_word(a));
    assign words[a] = WORD;
  end

  logic [K-2:0] idx;
  always_comb begin
    idx    = bits_i[0] ? bits_i[K-1:1] : ~bits_i[K-1:1];
    term_o = bits_i[0] ? words[idx] : -words[idx];
  end
endmodule

// File: rtl/da_scale_acc.sv
module da_scale_acc #(
  parameter int                 TW     = 18,
  parameter int                 SH     = 7,
  parameter int                 AW     = TW + SH,
  parameter logic signed [AW-1:0] OFFSET = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  init_i,
  input  logic                  step_i,
  input  logic                  sign_i,
  input  logic signed [TW-1:0]  term_i,
  output logic signed [AW-1:0]  sum_o
);
  logic signed [AW-1:0] acc_q;
  logic signed [AW:0]   term_w, acc_w, sum_w;

  always_comb begin
    term_w = (AW+1)'(term_i) <<< SH;
    acc_w  = (AW+1)'(acc_q);
    sum_w  = sign_i ? acc_w - term_w : acc_w + term_w;
    sum_o  = sum_w[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 acc_q <= '0;
    else if (init_i)             acc_q <= OFFSET;
    else if (step_i && !sign_i)  acc_q <= sum_o >>> 1;
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (sum_w[AW] == sum_w[AW-1]));
endmodule

// File: rtl/da_dot_product.sv
module da_dot_product
  import da_pkg::*;
#(
  parameter int K         = 4,
  parameter int N         = 8,
  parameter int COEF_W    = 16,
  parameter logic [K*COEF_W-1:0] COEFS = {16'h070A, 16'h3CCD, 16'hECCD, 16'h2E14},
  parameter int G         = $clog2(K),
  parameter int TW        = COEF_W + G,
  parameter int RES_W     = TW + N - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [K*N-1:0]           x_i,
  output logic signed [RES_W-1:0]  result_o,
  output logic                     valid_o
);
  localparam int CNT_W = (N > 1) ? $clog2(N) : 1;

  function automatic int coef_total();
    int s;
    s = 0;
    for (int k = 0; k < K; k++) s = s + coef_val(1024'(COEFS), k, COEF_W);
    return s;
  endfunction

  localparam int HALF_SUM = coef_total() >>> 1;
  localparam logic signed [RES_W-1:0] OFFSET =
    RES_W'(longint'(-HALF_SUM) * (longint'(1) << (N - 1)));

  da_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 accept, run, last;
  logic [K-1:0]         bits;
  logic signed [TW-1:0] term;
  logic signed [RES_W-1:0] sum;

  assign accept = start_i && (state_q == ST_IDLE);
  assign run    = (state_q == ST_RUN);
  assign last   = run && (cnt_q == CNT_W'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (last) begin
      state_q <= ST_IDLE;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  da_shift_bank #(.K(K), .N(N)) i_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .shift_i(run),
    .data_i(x_i), .bits_o(bits)
  );

  da_half_rom #(.K(K), .COEF_W(COEF_W), .COEFS(COEFS), .TW(TW)) i_rom (
    .bits_i(bits), .term_o(term)
  );

  da_scale_acc #(.TW(TW), .SH(N - 1), .AW(RES_W), .OFFSET(OFFSET)) i_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(accept), .step_i(run),
    .sign_i(last), .term_i(term), .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= last;
      if (last) result_o <= sum;
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_valid_after_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(run) && ($past(cnt_q) == CNT_W'(N - 1)));
  assert_result_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
  assert_start_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !last && start_i) |=> run && (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: tb/test_da_dot_product.sv
`timescale 1ns/1ps
module test_da_dot_product;
  localparam int K     = 4;
  localparam int N     = 8;
  localparam int RES_W = 16 + 2 + N - 1;
  localparam real CLK_NS = 20.0;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [K*N-1:0] x_i = '0;
  logic signed [RES_W-1:0] result_o;
  logic valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  da_dot_product i_da_dot_product (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .x_i(x_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  function automatic longint coef(input int k);
    case (k)
      0: return 11796;
      1: return -4915;
      2: return 15565;
      default: return 1802;
    endcase
  endfunction

  function automatic longint expect_dot(input logic [K*N-1:0] xv);
    longint e;
    logic [N-1:0] s;
    e = 0;
    for (int k = 0; k < K; k++) begin
      s = xv[k*N +: N];
      e += coef(k) * longint'($signed(s));
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_result(input string req, input longint exp);
    longint act, d;
    act = longint'(result_o);
    d = act - exp;
    chk((d <= 1) && (d >= -1), req, act, exp);
  endtask

  // start, measure latency, check value, pulse width and hold
  task automatic run_op(input logic [K*N-1:0] xv, input string req);
    int lat;
    longint exp;
    logic signed [RES_W-1:0] held;
    exp = expect_dot(xv);
    @(negedge clk_i);
    x_i = xv; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!valid_o && lat < 4*N) begin @(negedge clk_i); lat++; end
    chk(lat == N, "R3 latency", lat, N);
    check_result(req, exp);
    held = result_o;
    @(negedge clk_i);
    chk(!valid_o, "R3 pulse width", valid_o, 0);
    repeat (3) @(negedge clk_i);
    chk(result_o == held, "R4 hold", longint'(result_o), longint'(held));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lat, extra;
    longint exp_a;
    logic [K*N-1:0] va, vb;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk(!valid_o, "R1 valid", valid_o, 0);
    chk(result_o == '0, "R1 result", longint'(result_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 corners
    run_op({K{8'h00}}, "R6 zero");
    run_op({K{8'h80}}, "R6 all minus one");
    run_op({K{8'h7F}}, "R6 all max");
    run_op({8'h7F, 8'h80, 8'h7F, 8'h80}, "R6 mixed sign a");
    run_op({8'h80, 8'h7F, 8'h80, 8'h7F}, "R6 mixed sign b");
    run_op({8'h01, 8'hFF, 8'h01, 8'hFF}, "R6 small");

    // R5 start during run is ignored
    va = {8'h35, 8'hC2, 8'h11, 8'h9A};
    vb = {8'h7F, 8'h7F, 8'h7F, 8'h7F};
    exp_a = expect_dot(va);
    @(negedge clk_i);
    x_i = va; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    @(negedge clk_i);
    x_i = vb; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 2;
    while (!valid_o && lat < 4*N) begin @(negedge clk_i); lat++; end
    chk(lat == N, "R5 latency kept", lat, N);
    check_result("R5 result from first start", exp_a);
    extra = 0;
    repeat (N + 4) begin @(negedge clk_i); if (valid_o) extra++; end
    chk(extra == 0, "R5 no extra valid", extra, 0);
    check_result("R5 result still first", exp_a);

    // R2 random
    for (int i = 0; i < 40; i++) begin
      run_op({$urandom, $urandom} & {K*N{1'b1}}, "R2 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule